// File: doc/BRIEF.md
# NAND Flash Ready/Busy and Interrupt Status Unit

This unit gathers the events a NAND flash controller reports to its host and turns them into one interrupt line. Up to four ready/busy inputs from flash dies are brought into the clock domain through synchronizer chains. Their live levels can be read back at any time. A rising edge on the one pin chosen in the control register marks a busy-to-ready event. Pulses from the command engine (command finished) and the DMA engine (transfer finished) are latched in the same sticky flag register.

Each flag has its own interrupt enable. The interrupt output is the registered OR of every flag that is both set and enabled. Software acknowledges a flag by writing a one to its bit. A self-timed soft reset, started from the control register, wipes the flags and enables. While it runs, the unit drives a reset strobe to the rest of the controller. The register port is a plain word-addressed write strobe with registered read data.

Top module: `nand_irq_status`

## Requirements
- R1: After reset, the control register (word 0) and the enable register (word 2) read 0 and `irq_o` and `soft_rst_o` are low. The status register (word 1) reads 0x00000F00 while all four pins are held high (ready).
- R2: Status bits 11:8 show the synchronized levels of `rb_i[3:0]`, with pin n on bit 8+n.
- R3: A low-to-high change of the pin whose index is held in control bits 4:3 sets status bit 0. The same change on any other pin leaves status bit 0 unchanged.
- R4: A one-cycle pulse on `cmd_done_i` sets status bit 1 and a pulse on `dma_done_i` sets status bit 2. Each flag stays set until cleared.
- R5: Status bit 3 reads 1 while `cmd_busy_i` is high and 0 while it is low.
- R6: Writing to word 1 clears each flag in bits 2:0 whose data bit is 1 and leaves flags with a 0 data bit unchanged. An event that arrives in the same cycle as a clear of its flag leaves the flag set.
- R7: Enable register bits 2:0 gate status bits 2:0 bit for bit. `irq_o` goes high one clock after any enabled flag is set, and a set flag whose enable is 0 never raises `irq_o`.
- R8: Writing 1 to control bit 1 starts a soft reset. That bit reads 1 and `soft_rst_o` is high for exactly 4 clock cycles, after which both return to 0 without software action.
- R9: A soft reset clears all flags and all enables. Events that arrive while it runs are discarded. The pin select in control bits 4:3 is kept.
- R10: `reg_rdata` holds the register addressed by `reg_addr` one clock earlier. Word addresses 3 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rb_i | input | 4 | Ready/busy pins from the flash dies, 1 = ready |
| cmd_done_i | input | 1 | One-cycle pulse: command engine finished |
| dma_done_i | input | 1 | One-cycle pulse: DMA transfer finished |
| cmd_busy_i | input | 1 | Command engine still holds unfinished work |
| reg_addr | input | 4 | Word address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the host |
| soft_rst_o | output | 1 | Soft reset strobe to the rest of the controller |

## Verification
Several checks run on every cycle. The assertions confirm that each event sets its flag unless a soft reset is running, and that a write-one clear drops a flag when no event competes with it. They also confirm that a soft reset leaves flags and enables at zero, that the interrupt stays low while every enable is zero, that the reset strobe ends only after its full count, and that unmapped reads return zero. Other behaviour is shown only by the directed scenarios: which pin feeds the edge detector, the mapping of pin levels to status bits, the busy bit, and the race between a clear and a new event. The scenarios also cover the duration of the soft reset as seen through the ports, and that the pin select survives a soft reset.

// File: rtl/nand_irq_pkg.sv
`timescale 1ns/1ps
package nand_irq_pkg;
  // word addresses of the register port
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_IEN  = 2;

  // event indices, shared by status and enable registers
  localparam int unsigned EVT_B2R = 0;
  localparam int unsigned EVT_CMD = 1;
  localparam int unsigned EVT_DMA = 2;
  localparam int unsigned NUM_EVT = 3;

  // bit positions that software decodes
  localparam int unsigned CTRL_SRST_BIT  = 1;
  localparam int unsigned CTRL_RBSEL_LSB = 3;
  localparam int unsigned STAT_BUSY_BIT  = 3;
  localparam int unsigned STAT_LVL_LSB   = 8;
endpackage

// File: rtl/nand_rb_sync.sv
`timescale 1ns/1ps
module nand_rb_sync #(
  parameter int unsigned NUM_RB      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = (NUM_RB > 1) ? $clog2(NUM_RB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_RB-1:0] rb_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_RB-1:0] level_o,
  output logic              rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_RB-1:0] prev_q;
  logic [NUM_RB-1:0] rise_vec;

  // one synchronizer chain per pin; chains reset to "ready"
  for (genvar p = 0; p < NUM_RB; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[SYNC_STAGES-2:0], rb_i[p]};
    end
    assign level_o[p] = chain_q[LAST];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= level_o;
  end

  // edges are found per pin and then selected, so moving the select
  // never fabricates an edge
  assign rise_vec = level_o & ~prev_q;
  assign rise_o   = rise_vec[sel_i];
endmodule

// File: rtl/nand_evt_flags.sv
`timescale 1ns/1ps
module nand_evt_flags #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               srst_i,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [NUM_EVT-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flags_q;
  logic [NUM_EVT-1:0] en_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst || srst_i) flags_q <= '0;
    else               flags_q <= (flags_q & ~clr_i) | set_i;  // set wins
  end

  always_ff @(posedge clk) begin
    if (rst || srst_i) en_q <= '0;
    else if (en_we_i)  en_q <= en_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_q & en_q);
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  assert_set_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ((|set_i) && !srst_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
    ((|(clr_i & ~set_i)) && !srst_i) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_q);

  assert_srst_wipes_R9: assert property (@(posedge clk) disable iff (rst)
    srst_i |=> (flags_q == '0 && en_q == '0));
endmodule

// File: rtl/nand_srst_ctl.sv
`timescale 1ns/1ps
module nand_srst_ctl #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      cnt_q <= '0;
      if (start_i) active_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_CNT) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

  assert_srst_start_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_q) |=> active_q);

  assert_srst_full_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(active_q) |-> ($past(cnt_q) == LAST_CNT));
endmodule

// File: rtl/nand_irq_status.sv
`timescale 1ns/1ps
module nand_irq_status #(
  parameter int unsigned NUM_RB      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SRST_HOLD   = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_RB-1:0] rb_i,
  input  logic              cmd_done_i,
  input  logic              dma_done_i,
  input  logic              cmd_busy_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              soft_rst_o
);
  import nand_irq_pkg::*;

  localparam int unsigned SEL_W = (NUM_RB > 1) ? $clog2(NUM_RB) : 1;

  logic                wr_ctrl, wr_stat, wr_ien;
  logic [SEL_W-1:0]    rb_sel_q;
  logic [NUM_RB-1:0]   rb_level;
  logic                b2r_rise;
  logic                srst_active;
  logic                srst_start;
  logic [NUM_EVT-1:0]  evt_set, evt_clr, flags, ien;
  logic [DATA_W-1:0]   rd_word;
  logic [DATA_W-1:0]   rdata_q;
  logic                unused_wdata;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(REG_CTRL));
  assign wr_stat = reg_we && (reg_addr == ADDR_W'(REG_STAT));
  assign wr_ien  = reg_we && (reg_addr == ADDR_W'(REG_IEN));

  assign unused_wdata = ^reg_wdata;

  // pin select survives a soft reset
  always_ff @(posedge clk) begin
    if (rst)          rb_sel_q <= '0;
    else if (wr_ctrl) rb_sel_q <= reg_wdata[CTRL_RBSEL_LSB +: SEL_W];
  end

  assign srst_start = wr_ctrl && reg_wdata[CTRL_SRST_BIT];

  nand_rb_sync #(
    .NUM_RB(NUM_RB), .SYNC_STAGES(SYNC_STAGES), .SEL_W(SEL_W)
  ) u_rb_sync (
    .clk(clk), .rst(rst), .rb_i(rb_i), .sel_i(rb_sel_q),
    .level_o(rb_level), .rise_o(b2r_rise)
  );

  nand_srst_ctl #(.HOLD(SRST_HOLD)) u_srst (
    .clk(clk), .rst(rst), .start_i(srst_start), .active_o(srst_active)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EVT_B2R] = b2r_rise;
    evt_set[EVT_CMD] = cmd_done_i;
    evt_set[EVT_DMA] = dma_done_i;
  end

  assign evt_clr = wr_stat ? reg_wdata[NUM_EVT-1:0] : '0;

  nand_evt_flags #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk(clk), .rst(rst), .srst_i(srst_active),
    .set_i(evt_set), .clr_i(evt_clr),
    .en_we_i(wr_ien), .en_wdata_i(reg_wdata[NUM_EVT-1:0]),
    .flags_o(flags), .en_o(ien), .irq_o(irq_o)
  );

  always_comb begin
    rd_word = '0;
    if (reg_addr == ADDR_W'(REG_CTRL)) begin
      rd_word[CTRL_SRST_BIT]                = srst_active;
      rd_word[CTRL_RBSEL_LSB +: SEL_W]      = rb_sel_q;
    end else if (reg_addr == ADDR_W'(REG_STAT)) begin
      rd_word[NUM_EVT-1:0]                  = flags;
      rd_word[STAT_BUSY_BIT]                = cmd_busy_i;
      rd_word[STAT_LVL_LSB +: NUM_RB]       = rb_level;
    end else if (reg_addr == ADDR_W'(REG_IEN)) begin
      rd_word[NUM_EVT-1:0]                  = ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign reg_rdata  = rdata_q;
  assign soft_rst_o = srst_active;

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > ADDR_W'(REG_IEN)) |=> (reg_rdata == '0));

  assert_srst_visible_R8: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_o && (reg_addr == ADDR_W'(REG_CTRL))) |=> reg_rdata[CTRL_SRST_BIT]);
endmodule

// File: tb/nand_irq_status_bench.sv
`timescale 1ns/1ps
module nand_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rb_i = 4'hF;
  logic        cmd_done_i = 1'b0;
  logic        dma_done_i = 1'b0;
  logic        cmd_busy_i = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic        soft_rst_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  nand_irq_status u_nand_irq_status (
    .clk(clk), .rst(rst), .rb_i(rb_i),
    .cmd_done_i(cmd_done_i), .dma_done_i(dma_done_i), .cmd_busy_i(cmd_busy_i),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .soft_rst_o(soft_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    @(negedge clk) cmd_done_i = 1'b1;
    @(negedge clk) cmd_done_i = 1'b0;
  endtask

  task automatic pulse_dma();
    @(negedge clk) dma_done_i = 1'b1;
    @(negedge clk) dma_done_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 soft_rst", {31'd0, soft_rst_o}, 32'd0);
    rd(4'd0, d); check("R1 ctrl", d, 32'h0);
    rd(4'd1, d); check("R1 status", d, 32'h0000_0F00);
    rd(4'd2, d); check("R1 enable", d, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    rb_i = 4'b1010;
    idle(4);
    rd(4'd1, d);
    check("R2 levels", {28'd0, d[11:8]}, 32'hA);
    check("R3 falling edge sets nothing", {31'd0, d[0]}, 32'd0);
    rb_i = 4'b0110;
    idle(4);
    rd(4'd1, d);
    check("R2 levels second pattern", {28'd0, d[11:8]}, 32'h6);
    wr(4'd1, 32'h7);
    rb_i = 4'b0000;
    idle(4);
  endtask

  task automatic t_b2r();
    logic [31:0] d;
    wr(4'd0, 32'h10);               // select pin 2
    rd(4'd0, d); check("R3 select readback", d, 32'h10);
    rb_i = 4'b1011;                  // rise on pins 0,1,3 only
    idle(5);
    rd(4'd1, d); check("R3 unselected pins ignored", {31'd0, d[0]}, 32'd0);
    rb_i = 4'b1111;                  // rise on pin 2
    idle(5);
    rd(4'd1, d); check("R3 selected pin rise", {31'd0, d[0]}, 32'd1);
    wr(4'd1, 32'h1);
    rd(4'd1, d); check("R6 clear b2r", {31'd0, d[0]}, 32'd0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse_cmd();
    rd(4'd1, d); check("R4 cmd flag", {29'd0, d[2:0]}, 32'h2);
    pulse_dma();
    idle(3);
    rd(4'd1, d); check("R4 both flags sticky", {29'd0, d[2:0]}, 32'h6);
    wr(4'd1, 32'h0);
    rd(4'd1, d); check("R6 zero write no effect", {29'd0, d[2:0]}, 32'h6);
    wr(4'd1, 32'h2);
    rd(4'd1, d); check("R6 clear only cmd", {29'd0, d[2:0]}, 32'h4);
    wr(4'd1, 32'h4);
    rd(4'd1, d); check("R6 clear dma", {29'd0, d[2:0]}, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    cmd_busy_i = 1'b1;
    rd(4'd1, d); check("R5 busy high", {31'd0, d[3]}, 32'd1);
    cmd_busy_i = 1'b0;
    rd(4'd1, d); check("R5 busy low", {31'd0, d[3]}, 32'd0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse_cmd();
    @(negedge clk);
    reg_addr = 4'd1; reg_wdata = 32'h2; reg_we = 1'b1; cmd_done_i = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; cmd_done_i = 1'b0;
    rd(4'd1, d); check("R6 set wins over clear", {31'd0, d[1]}, 32'd1);
    wr(4'd1, 32'h2);
    rd(4'd1, d); check("R6 clear after race", {31'd0, d[1]}, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse_dma();
    idle(3);
    check("R7 disabled flag no irq", {31'd0, irq_o}, 32'd0);
    wr(4'd2, 32'h4);
    idle(2);
    check("R7 enabled flag irq", {31'd0, irq_o}, 32'd1);
    wr(4'd1, 32'h4);
    idle(2);
    check("R7 irq drops on clear", {31'd0, irq_o}, 32'd0);
    wr(4'd2, 32'h2);
    pulse_dma();
    idle(2);
    check("R7 dma masked", {31'd0, irq_o}, 32'd0);
    pulse_cmd();
    idle(1);
    check("R7 cmd enabled irq", {31'd0, irq_o}, 32'd1);
    rd(4'd2, d); check("R7 enable readback", d, 32'h2);
    wr(4'd1, 32'h7);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    int hi;
    pulse_cmd();
    pulse_dma();
    wr(4'd2, 32'h7);
    wr(4'd0, 32'h12);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (soft_rst_o) hi++;
      @(negedge clk);
    end
    check("R8 strobe length", hi, 32'd4);
    rd(4'd0, d); check("R8 self clear, R9 select kept", d, 32'h10);
    rd(4'd1, d); check("R9 flags wiped", {29'd0, d[2:0]}, 32'h0);
    rd(4'd2, d); check("R9 enables wiped", d, 32'h0);
    check("R9 irq low", {31'd0, irq_o}, 32'd0);
    wr(4'd0, 32'h12);
    pulse_dma();
    rd(4'd0, d); check("R8 bit reads one while active", {31'd0, d[1]}, 32'd1);
    idle(6);
    rd(4'd1, d); check("R9 event during reset dropped", {29'd0, d[2:0]}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(4'd5, d); check("R10 unmapped word", d, 32'h0);
    rd(4'd15, d); check("R10 top word", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_levels();
    t_b2r();
    t_events();
    t_busy();
    t_race();
    t_irq();
    t_srst();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule